// File: doc/BRIEF.md
# Framebuffer Word to LCD Pixel Formatter

This block sits between a memory fetch engine and an LCD data bus. It takes a stream of 32-bit words read from a framebuffer and turns each one into one or more pixels or bus beats, presenting exactly one of them per dot clock. Software picks the pixel storage format with a word-length setting and a byte-valid mask, the physical bus width with a two-bit width code, and whether 8-bit colour components are narrowed to 6 bits for an 18-bit panel.

Packed 16-bit pixels come out two per word, least significant halfword first, and on an 8-bit bus each halfword is further split into two byte beats, low byte first. Words holding one 24-bit pixel come out once per word, with the top byte ignored. The input stalls through `in_ready` while a packed word is still being unpacked. Any setting the block cannot serve raises `cfg_err`; in that state every offered word is taken and dropped, and no pixel comes out.

Top module: `lcd_pixel_formatter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pix_valid` is 0 and `in_ready` is 1.
- R2: `cfg_word_len` code 0 means packed 16-bit pixels and requires `cfg_byte_mask` = 4'hF; code 3 means one 24-bit pixel per word and requires `cfg_byte_mask` = 4'h7; codes 1 and 2, or any other mask, set `cfg_err`, hold `in_ready` at 1 and keep `pix_valid` at 0.
- R3: With word-length code 0 and a bus code of 1, 2 or 3 (16, 18 or 24 bits), each accepted word yields two pixels on `pix_data[15:0]` with upper bits 0: first `in_data[15:0]`, then `in_data[31:16]`, RGB565 bits unchanged (red 15:11, green 10:5, blue 4:0).
- R4: `in_ready` is 0 on every cycle in which a further pixel or beat of the current word is still to be presented, and 1 otherwise, so words are taken back to back with no idle cycle on the pixel bus.
- R5: With word-length code 0 and bus code 0 (8 bits), each word yields four beats on `pix_data[7:0]` in the order bits 7:0, 15:8, 23:16, 31:24, upper bits 0.
- R6: With word-length code 3 and bus code 3 (24 bits), each word yields one pixel equal to `in_data[23:0]` (red 23:16, green 15:8, blue 7:0); `in_data[31:24]` has no effect.
- R7: With word-length code 3, bus code 1 or 2 and `cfg_reduce` = 1, each word yields one pixel `{in_data[21:16], in_data[13:8], in_data[5:0]}` on `pix_data[17:0]`, bits 23:18 being 0.
- R8: `cfg_reduce` has no effect in 16-bit mode or on the 24-bit bus.
- R9: Word-length code 3 with bus code 0, or with bus code 1 or 2 and `cfg_reduce` = 0, sets `cfg_err` with the behaviour of R2.
- R10: The first pixel of a word appears in the cycle after the word is accepted; `pix_valid` is 0 in any cycle that has no pending pixel of an accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word_len | input | 2 | Pixel storage code: 0 packed 16-bit, 3 24-bit in 32-bit word |
| cfg_byte_mask | input | 4 | Valid-byte mask of each word |
| cfg_bus_width | input | 2 | LCD bus code: 0 8-bit, 1 16-bit, 2 18-bit, 3 24-bit |
| cfg_reduce | input | 1 | Narrow 8-bit components to their low 6 bits |
| in_valid | input | 1 | Word offered |
| in_data | input | 32 | Framebuffer word |
| in_ready | output | 1 | Word taken when high together with `in_valid` |
| pix_valid | output | 1 | `pix_data` holds a pixel or beat this cycle |
| pix_data | output | 24 | Pixel bus, right-aligned |
| cfg_err | output | 1 | Current setting is unsupported |

## Verification
The assertions take the four configuration inputs as static while any piece of an accepted word is still pending; a setting changed in the middle of a packed word would reinterpret the held word. The stimulus therefore drops `in_valid`, waits until every expected pixel has been seen and one more quiet cycle has passed, and only then applies a new setting. Within a setting, `in_valid` and `in_data` are random with a fixed seed, with directed words placed first to expose byte order and ignored upper bits.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;

    typedef enum logic [1:0] {
        WL_16  = 2'd0,
        WL_R1  = 2'd1,
        WL_R2  = 2'd2,
        WL_32  = 2'd3
    } word_len_e;

    typedef enum logic [1:0] {
        BUS_8  = 2'd0,
        BUS_16 = 2'd1,
        BUS_18 = 2'd2,
        BUS_24 = 2'd3
    } bus_width_e;

    typedef enum logic [1:0] {
        FMT_HALF,
        FMT_BYTE,
        FMT_FULL,
        FMT_SIX
    } piece_fmt_e;

    typedef struct packed {
        logic       err;
        piece_fmt_e fmt;
        logic [1:0] last_idx;
    } unpack_plan_t;

    localparam logic [3:0] MASK_PACKED = 4'hF;
    localparam logic [3:0] MASK_SINGLE = 4'h7;

    function automatic logic [17:0] squeeze666(input logic [23:0] rgb);
        return {rgb[21:16], rgb[13:8], rgb[5:0]};
    endfunction

endpackage

// File: rtl/lpf_cfg_decode.sv
module lpf_cfg_decode
    import lpf_pkg::*;
(
    input  logic [1:0]   word_len,
    input  logic [3:0]   byte_mask,
    input  logic [1:0]   bus_width,
    input  logic         reduce,
    output unpack_plan_t plan
);

    always_comb begin
        plan.err      = 1'b0;
        plan.fmt      = FMT_HALF;
        plan.last_idx = 2'd1;
        case (word_len)
            WL_16: begin
                if (byte_mask != MASK_PACKED) begin
                    plan.err = 1'b1;
                end else if (bus_width == BUS_8) begin
                    plan.fmt      = FMT_BYTE;
                    plan.last_idx = 2'd3;
                end
            end
            WL_32: begin
                plan.last_idx = 2'd0;
                if (byte_mask != MASK_SINGLE || bus_width == BUS_8) begin
                    plan.err = 1'b1;
                end else if (bus_width == BUS_24) begin
                    plan.fmt = FMT_FULL;
                end else if (reduce) begin
                    plan.fmt = FMT_SIX;
                end else begin
                    plan.err = 1'b1;
                end
            end
            default: plan.err = 1'b1;
        endcase
    end

endmodule

// File: rtl/lpf_piece_format.sv
module lpf_piece_format
    import lpf_pkg::*;
#(
    parameter int W_IN  = WORD_W,
    parameter int W_OUT = PIX_W
) (
    input  logic [W_IN-1:0]  word,
    input  logic [1:0]       idx,
    input  piece_fmt_e       fmt,
    output logic [W_OUT-1:0] pix
);

    localparam int HALF_W = W_IN / 2;
    localparam int BYTE_W = 8;

    always_comb begin
        pix = '0;
        case (fmt)
            FMT_HALF: pix[HALF_W-1:0] = idx[0] ? word[W_IN-1:HALF_W] : word[HALF_W-1:0];
            FMT_BYTE: pix[BYTE_W-1:0] = word[BYTE_W*idx +: BYTE_W];
            FMT_FULL: pix[23:0]       = word[23:0];
            FMT_SIX:  pix[17:0]       = squeeze666(word[23:0]);
            default:  pix             = '0;
        endcase
    end

endmodule

// File: rtl/lcd_pixel_formatter.sv
module lcd_pixel_formatter
    import lpf_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int OUT_W  = PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_word_len,
    input  logic [3:0]        cfg_byte_mask,
    input  logic [1:0]        cfg_bus_width,
    input  logic              cfg_reduce,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              pix_valid,
    output logic [OUT_W-1:0]  pix_data,
    output logic              cfg_err
);

    unpack_plan_t      plan;
    logic              active;
    logic [1:0]        idx;
    logic [DATA_W-1:0] hold;
    logic              more;
    logic              accept;

    lpf_cfg_decode u_decode (
        .word_len (cfg_word_len),
        .byte_mask(cfg_byte_mask),
        .bus_width(cfg_bus_width),
        .reduce   (cfg_reduce),
        .plan     (plan)
    );

    lpf_piece_format #(.W_IN(DATA_W), .W_OUT(OUT_W)) u_format (
        .word(hold),
        .idx (idx),
        .fmt (plan.fmt),
        .pix (pix_data)
    );

    assign more     = active && (idx != plan.last_idx);
    assign in_ready = plan.err || !more;
    assign accept   = in_valid && in_ready && !plan.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= 2'd0;
            hold   <= '0;
        end else if (plan.err) begin
            active <= 1'b0;
            idx    <= 2'd0;
        end else if (more) begin
            idx <= idx + 2'd1;
        end else if (in_valid) begin
            active <= 1'b1;
            idx    <= 2'd0;
            hold   <= in_data;
        end else begin
            active <= 1'b0;
        end
    end

    assign pix_valid = active && !plan.err;
    assign cfg_err   = plan.err;

    // A packed halfword word keeps the input stalled for its second pixel
    assert_half_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && plan.fmt == FMT_HALF) |=> (pix_valid && !in_ready));

    // A single-pixel word is shown next cycle and the input stays open
    assert_single_flow_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && (plan.fmt == FMT_FULL || plan.fmt == FMT_SIX)) |=> (pix_valid && in_ready));

    // No offered word while open means nothing is shown next cycle
    assert_no_phantom_R10: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !pix_valid);

    // Unsupported setting swallows words and shows nothing
    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (in_ready && !pix_valid));

    // 24-bit pixels cannot go out on an 8-bit bus
    assert_bus8_reject_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_word_len == WL_32 && cfg_bus_width == BUS_8) |-> cfg_err);

    // Narrowed pixels leave the top six bus bits at zero
    assert_six_top_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && plan.fmt == FMT_SIX) |-> (pix_data[23:18] == 6'd0));

endmodule

// File: tb/lcd_pixel_formatter_test.sv
`timescale 1ns/1ps
module lcd_pixel_formatter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_word_len = 2'd0;
    logic [3:0]  cfg_byte_mask = 4'hF;
    logic [1:0]  cfg_bus_width = 2'd1;
    logic        cfg_reduce = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        in_ready;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    logic [23:0] q[$];
    int unsigned seed_sink;

    always #10 clk = ~clk;

    lcd_pixel_formatter uut (
        .clk(clk), .rst(rst),
        .cfg_word_len(cfg_word_len), .cfg_byte_mask(cfg_byte_mask),
        .cfg_bus_width(cfg_bus_width), .cfg_reduce(cfg_reduce),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .pix_valid(pix_valid), .pix_data(pix_data), .cfg_err(cfg_err)
    );

    function automatic bit exp_err();
        if (cfg_word_len == 2'd0) return cfg_byte_mask != 4'hF;
        if (cfg_word_len == 2'd3) begin
            if (cfg_byte_mask != 4'h7) return 1'b1;
            if (cfg_bus_width == 2'd0) return 1'b1;
            if (cfg_bus_width != 2'd3 && !cfg_reduce) return 1'b1;
            return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic string pix_tag();
        if (cfg_word_len == 2'd0) begin
            if (cfg_bus_width == 2'd0) return "R5";
            return cfg_reduce ? "R8" : "R3";
        end
        if (cfg_bus_width == 2'd3) return cfg_reduce ? "R8" : "R6";
        return "R7";
    endfunction

    function automatic string err_tag();
        if (cfg_word_len == 2'd3 && cfg_byte_mask == 4'h7) return "R9";
        return "R2";
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_expected(input logic [31:0] w);
        if (cfg_word_len == 2'd0) begin
            if (cfg_bus_width == 2'd0) begin
                for (int b = 0; b < 4; b++) q.push_back({16'h0, w[8*b +: 8]});
            end else begin
                q.push_back({8'h0, w[15:0]});
                q.push_back({8'h0, w[31:16]});
            end
        end else if (cfg_bus_width == 2'd3) begin
            q.push_back(w[23:0]);
        end else begin
            q.push_back({6'h0, w[21:16], w[13:8], w[5:0]});
        end
    endtask

    task automatic step(input bit v, input logic [31:0] d);
        logic [23:0] e;
        bit ee;
        bit ev;
        @(negedge clk);
        ee = exp_err();
        ev = (q.size() > 0) && !ee;
        check(pix_valid == ev, "R10", {31'd0, pix_valid}, {31'd0, ev});
        if (ev) begin
            e = q.pop_front();
            check(pix_data == e, pix_tag(), {8'd0, pix_data}, {8'd0, e});
        end
        check(in_ready == (ee || q.size() == 0), "R4", {31'd0, in_ready}, {31'd0, (ee || q.size() == 0)});
        check(cfg_err == ee, err_tag(), {31'd0, cfg_err}, {31'd0, ee});
        in_valid = v;
        in_data  = d;
        if (v && in_ready && !ee) push_expected(d);
    endtask

    task automatic drain();
        while (q.size() > 0) step(1'b0, 32'd0);
        step(1'b0, 32'd0);
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic [3:0] m, input logic [1:0] bw, input logic r);
        drain();
        cfg_word_len  = wl;
        cfg_byte_mask = m;
        cfg_bus_width = bw;
        cfg_reduce    = r;
    endtask

    task automatic random_run(input int n, input int pct);
        for (int i = 0; i < n; i++) step(($urandom % 100) < pct, $urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        check(pix_valid == 1'b0, "R1", {31'd0, pix_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check(pix_valid == 1'b0, "R1", {31'd0, pix_valid}, 32'd0);
        check(in_ready == 1'b1, "R1", {31'd0, in_ready}, 32'd1);

        // R3: low halfword first, then high
        step(1'b1, 32'hABCD1234);
        step(1'b1, 32'h0F0F_F0F0);
        drain();
        random_run(300, 70);

        // R8: reduce flag in 16-bit mode on an 18-bit bus
        set_cfg(2'd0, 4'hF, 2'd2, 1'b1);
        step(1'b1, 32'h8001_7FFE);
        random_run(300, 90);

        // R5: byte beats on the 8-bit bus
        set_cfg(2'd0, 4'hF, 2'd0, 1'b0);
        step(1'b1, 32'h4433_2211);
        random_run(300, 80);

        // R6: top byte ignored
        set_cfg(2'd3, 4'h7, 2'd3, 1'b0);
        step(1'b1, 32'hFF12_3456);
        step(1'b1, 32'h0012_3456);
        random_run(300, 75);

        // R8: reduce ignored on the 24-bit bus
        set_cfg(2'd3, 4'h7, 2'd3, 1'b1);
        step(1'b1, 32'hC0C0_C0C0);
        random_run(200, 60);

        // R7: six-bit components on 18- and 16-bit buses
        set_cfg(2'd3, 4'h7, 2'd2, 1'b1);
        step(1'b1, 32'hFFC3_81FF);
        random_run(300, 85);
        set_cfg(2'd3, 4'h7, 2'd1, 1'b1);
        random_run(200, 50);

        // R9: rejected bus combinations
        set_cfg(2'd3, 4'h7, 2'd0, 1'b1);
        random_run(40, 80);
        set_cfg(2'd3, 4'h7, 2'd1, 1'b0);
        random_run(40, 80);

        // R2: reserved codes and wrong masks
        set_cfg(2'd1, 4'hF, 2'd1, 1'b0);
        random_run(40, 80);
        set_cfg(2'd2, 4'h7, 2'd3, 1'b0);
        random_run(40, 80);
        set_cfg(2'd3, 4'hF, 2'd3, 1'b0);
        random_run(40, 80);
        set_cfg(2'd0, 4'h7, 2'd1, 1'b0);
        random_run(40, 80);

        // back to a valid mode to confirm recovery (R3)
        set_cfg(2'd0, 4'hF, 2'd3, 1'b0);
        random_run(200, 100);
        drain();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule